// File: doc/BRIEF.md
# LDPC Early-Termination Controller

This controller sequences iterations for an iterative LDPC decoder whose variable and check units exchange bit-serial messages in fixed windows of four cycles. Two frames share the decoder in alternation. During each window the check units work on one frame slot and the variable units work on the other, and the roles swap when the window ends. One iteration of a frame is one check window followed by one variable window, so it lasts eight cycles. A frame is given a budget of fifteen iterations.

The check units report one parity flag each for the variable-to-check messages they have just received. A flag of 1 means that check is unsatisfied. The controller reduces all flags through a balanced OR tree. When the tree output is 0 at the end of a frame's check window, and the frame has already completed at least one iteration, the frame is marked converged. Both unit enables for that slot then stay low for the rest of its budget. A one-cycle decision strobe tells the variable units to latch their hard decisions at the start of the next iteration. Frame start points are not moved by early termination, so throughput does not change. Only switching activity is saved.

Top module: `ldpc_term_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, `check_enable_o`, `variable_enable_o`, `done_o` and `decide_o` are all 0, and they stay 0 until a frame is loaded.
- R2: Windows are 4 cycles long. In the first window after reset the check side serves slot 0 and the variable side serves slot 1, and the roles swap every window. `new_frame_i` is accepted only on the last cycle of a window. It loads the slot that is then on the variable side, and that slot's first check window starts on the next cycle. A pulse at any other cycle is ignored.
- R3: During a window, `check_enable_o` (resp. `variable_enable_o`) is 1 exactly when the slot on that side is loaded, has not used up its budget and has not converged.
- R4: The parity flags are combined by OR, with 1 meaning unsatisfied. Any single flag at 1 in the sampling cycle prevents convergence, and all flags at 0 allow it.
- R5: Parity is sampled only on the last cycle of the slot's check window, and only once the slot has completed at least one iteration. All-zero parity during the first iteration is ignored.
- R6: Once a slot converges, both enables for that slot stay 0 for the rest of its budget.
- R7: A slot's budget is 15 iterations (120 cycles). `done_o[s]` rises in the cycle after the edge that ends the 15th variable window, which is 120 cycles after the load edge. It stays high until the slot is loaded again.
- R8: `decide_o[s]` is a single-cycle pulse, once per frame. It appears in the first cycle after the variable window that follows convergence, or after the 15th iteration if the frame never converges. A load at that same edge does not suppress it.
- R9: A new load of a slot restarts it. The iteration count is cleared, the converged and done state is cleared, and the slot's enables return in its next windows, even in the middle of a frame.
- R10: The time from load to the rise of `done_o` is the same 120 cycles whether or not the frame terminated early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| new_frame_i | input | 1 | Load request for the slot on the variable side, taken at window end |
| parity_i | input | NUM_CHECKS | Per-check parity flag, 1 = unsatisfied |
| check_enable_o | output | 1 | Enable for the check units in the current window |
| variable_enable_o | output | 1 | Enable for the variable units in the current window |
| done_o | output | 2 | Per-slot budget finished flag |
| decide_o | output | 2 | Per-slot hard-decision strobe |

## Verification
The bench applies several parity patterns. A walking single set bit must never terminate a frame, while all-zero parity from the first cycle separates sampling in the first iteration from the required second-iteration start. Convergence targets of zero, two, three and none per slot tell apart the early strobe, the budget-end strobe and the fixed rise of `done_o`. Loads are also placed at off-boundary cycles, in the middle of a frame and exactly on a budget-end edge. These show that off-boundary pulses are ignored, that a reload restores the enables, and that a reload does not swallow a pending strobe.

// File: rtl/ldpc_et_pkg.sv
package ldpc_et_pkg;
  localparam int NUM_SLOTS = 2;
  typedef logic [NUM_SLOTS-1:0] slot_vec_t;
endpackage

// File: rtl/ldpc_window_timer.sv
module ldpc_window_timer #(
  parameter int PHASE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic side_o,
  output logic win_end_o
);
  localparam int PH_W = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASE_LEN - 1);

  logic [PH_W-1:0] phase_q;
  logic            side_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      side_q  <= 1'b0;
    end else if (phase_q == LAST_PH) begin
      phase_q <= '0;
      side_q  <= ~side_q;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign side_o    = side_q;
  assign win_end_o = (phase_q == LAST_PH);
endmodule

// File: rtl/ldpc_parity_tree.sv
module ldpc_parity_tree #(
  parameter int N = 16
) (
  input  logic [N-1:0] flags_i,
  output logic         any_o
);
  localparam int LVL = (N > 1) ? $clog2(N) : 0;
  localparam int P   = 1 << LVL;

  for (genvar k = 0; k <= LVL; k++) begin : g_lvl
    logic [(P>>k)-1:0] v;
    if (k == 0) begin : g_leaf
      for (genvar i = 0; i < P; i++) begin : g_in
        if (i < N) begin : g_real
          assign v[i] = flags_i[i];
        end else begin : g_pad
          assign v[i] = 1'b0;
        end
      end
    end else begin : g_or
      for (genvar i = 0; i < (P >> k); i++) begin : g_pair
        assign v[i] = g_lvl[k-1].v[2*i] | g_lvl[k-1].v[2*i+1];
      end
    end
  end

  assign any_o = g_lvl[LVL].v[0];
endmodule

// File: rtl/ldpc_slot_seq.sv
module ldpc_slot_seq #(
  parameter int MAX_ITERS = 15,
  parameter int IT_W      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic chk_end_i,
  input  logic var_end_i,
  input  logic all_sat_i,
  output logic enable_o,
  output logic done_o,
  output logic decide_o
);
  localparam logic [IT_W-1:0] LAST_IT = IT_W'(MAX_ITERS - 1);

  logic            busy_q, conv_q, decided_q, done_q, decide_q;
  logic [IT_W-1:0] iter_q;
  logic            final_it, it_end, conv_hit;

  assign final_it = (iter_q == LAST_IT);
  assign it_end   = var_end_i & busy_q;
  // no sampling before one full check-to-variable update
  assign conv_hit = chk_end_i & busy_q & ~conv_q & (iter_q != '0) & all_sat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      conv_q    <= 1'b0;
      decided_q <= 1'b0;
      done_q    <= 1'b0;
      decide_q  <= 1'b0;
      iter_q    <= '0;
    end else begin
      // strobe is independent of a same-edge reload
      decide_q <= it_end & ~decided_q & (conv_q | final_it);
      if (load_i) begin
        busy_q    <= 1'b1;
        conv_q    <= 1'b0;
        decided_q <= 1'b0;
        done_q    <= 1'b0;
        iter_q    <= '0;
      end else begin
        if (conv_hit) conv_q <= 1'b1;
        if (it_end) begin
          iter_q <= iter_q + 1'b1;
          if (conv_q | final_it) decided_q <= 1'b1;
          if (final_it) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign enable_o = busy_q & ~conv_q;
  assign done_o   = done_q;
  assign decide_o = decide_q;
endmodule

// File: rtl/ldpc_term_ctrl.sv
module ldpc_term_ctrl
  import ldpc_et_pkg::*;
#(
  parameter int NUM_CHECKS = 16,
  parameter int MAX_ITERS  = 15,
  parameter int PHASE_LEN  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  new_frame_i,
  input  logic [NUM_CHECKS-1:0] parity_i,
  output logic                  check_enable_o,
  output logic                  variable_enable_o,
  output logic [NUM_SLOTS-1:0]  done_o,
  output logic [NUM_SLOTS-1:0]  decide_o
);
  localparam int IT_W = $clog2(MAX_ITERS + 1);

  logic      side, win_end, any_unsat;
  slot_vec_t chk_end, var_end, load, slot_en;

  ldpc_window_timer #(.PHASE_LEN(PHASE_LEN)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .side_o    (side),
    .win_end_o (win_end)
  );

  ldpc_parity_tree #(.N(NUM_CHECKS)) u_tree (
    .flags_i (parity_i),
    .any_o   (any_unsat)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign chk_end[s] = win_end & (side == 1'(s));
    assign var_end[s] = win_end & (side != 1'(s));
    assign load[s]    = new_frame_i & var_end[s];

    ldpc_slot_seq #(.MAX_ITERS(MAX_ITERS), .IT_W(IT_W)) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load[s]),
      .chk_end_i (chk_end[s]),
      .var_end_i (var_end[s]),
      .all_sat_i (~any_unsat),
      .enable_o  (slot_en[s]),
      .done_o    (done_o[s]),
      .decide_o  (decide_o[s])
    );
  end

  assign check_enable_o    = slot_en[side];
  assign variable_enable_o = slot_en[~side];
endmodule

// File: rtl/ldpc_term_ctrl_chk.sv
module ldpc_term_ctrl_chk
  import ldpc_et_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      win_end_i,
  input logic      check_enable_i,
  input logic      variable_enable_i,
  input slot_vec_t done_i,
  input slot_vec_t decide_i
);
  assert_decide_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(decide_i));

  assert_decide_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|decide_i) |=> !(|decide_i));

  assert_decide_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|decide_i) |-> $past(win_end_i));

  assert_chk_en_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (check_enable_i != $past(check_enable_i)) |-> $past(win_end_i));

  assert_var_en_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variable_enable_i != $past(variable_enable_i)) |-> $past(win_end_i));

  assert_done_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i[0]) |-> !check_enable_i);
endmodule

bind ldpc_term_ctrl ldpc_term_ctrl_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .win_end_i         (win_end),
  .check_enable_i    (check_enable_o),
  .variable_enable_i (variable_enable_o),
  .done_i            (done_o),
  .decide_i          (decide_o)
);

// File: tb/ldpc_term_ctrl_tb.sv
module ldpc_term_ctrl_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NC   = 16;
  localparam int MAXI = 15;
  localparam int PL   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          nf = 1'b0;
  logic [NC-1:0] par = '1;
  logic          ce, ve;
  logic [1:0]    done, dec;

  always #2.5 clk = ~clk;

  ldpc_term_ctrl #(.NUM_CHECKS(NC), .MAX_ITERS(MAXI), .PHASE_LEN(PL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .new_frame_i(nf), .parity_i(par),
    .check_enable_o(ce), .variable_enable_o(ve), .done_o(done), .decide_o(dec)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string scen = "R1";

  // behavioural reference
  int m_phase, m_side, cyc, walk;
  int m_busy[2], m_conv[2], m_decd[2], m_done[2], m_iter[2], m_dec[2];
  int target[2], load_cyc[2], done_at[2], dec_at[2], prev_done[2];

  task automatic model_clear();
    m_phase = 0; m_side = 0;
    for (int s = 0; s < 2; s++) begin
      m_busy[s] = 0; m_conv[s] = 0; m_decd[s] = 0;
      m_done[s] = 0; m_iter[s] = 0; m_dec[s] = 0;
    end
  endtask

  task automatic model_step();
    int pe;
    pe = (m_phase == PL - 1);
    for (int s = 0; s < 2; s++) begin
      int c_end, v_end, ld, itend;
      c_end = pe && (m_side == s);
      v_end = pe && (m_side != s);
      ld    = nf && v_end;
      itend = v_end && m_busy[s];
      m_dec[s] = itend && !m_decd[s] && (m_conv[s] || m_iter[s] == MAXI - 1);
      if (ld) begin
        m_busy[s] = 1; m_conv[s] = 0; m_decd[s] = 0; m_done[s] = 0; m_iter[s] = 0;
      end else begin
        if (c_end && m_busy[s] && !m_conv[s] && m_iter[s] > 0 && par == '0)
          m_conv[s] = 1;
        if (itend) begin
          if (m_conv[s] || m_iter[s] == MAXI - 1) m_decd[s] = 1;
          if (m_iter[s] == MAXI - 1) begin m_busy[s] = 0; m_done[s] = 1; end
          m_iter[s]++;
        end
      end
    end
    if (pe) begin m_phase = 0; m_side ^= 1; end
    else m_phase++;
  endtask

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] cyc %0d: got %0d expected %0d", tag, scen, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R3 check_enable", int'(ce), (m_busy[m_side] && !m_conv[m_side]) ? 1 : 0);
    check("R3 variable_enable", int'(ve), (m_busy[1-m_side] && !m_conv[1-m_side]) ? 1 : 0);
    for (int s = 0; s < 2; s++) begin
      check("R7 done", int'(done[s]), m_done[s]);
      check("R8 decide", int'(dec[s]), m_dec[s]);
      if (done[s] && !prev_done[s] && done_at[s] < 0) done_at[s] = cyc;
      if (dec[s] && dec_at[s] < 0) dec_at[s] = cyc;
      prev_done[s] = done[s];
    end
  endtask

  task automatic tick();
    int cs;
    cs = m_side;
    if (m_busy[cs] && m_iter[cs] >= target[cs]) par = '0;
    else par = NC'(1) << (walk % NC);
    walk++;
    @(negedge clk);
    cyc++;
    if (rst_n) model_step(); else model_clear();
    compare_all();
  endtask

  task automatic clear_rec(int s);
    done_at[s] = -1; dec_at[s] = -1;
  endtask

  task automatic load(int s);
    while (!(m_phase == PL - 1 && m_side != s)) tick();
    nf = 1'b1;
    tick();
    nf = 1'b0;
    load_cyc[s] = cyc;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    cyc = 0; walk = 0;
    model_clear();
    for (int s = 0; s < 2; s++) begin
      target[s] = 99; prev_done[s] = 0; clear_rec(s);
    end
    // R1: reset state
    run(3);
    check("R1 reset enables", int'(ce | ve), 0);
    check("R1 reset flags", int'(done | dec), 0);
    @(negedge clk); rst_n = 1'b1;
    run(5);
    check("R1 idle after release", int'({ce, ve, done, dec}), 0);

    // R2: off-boundary new_frame ignored
    scen = "R2 off-boundary load";
    while (m_phase == PL - 1) tick();
    nf = 1'b1; tick(); nf = 1'b0;
    run(10);
    check("R2 ignored pulse keeps enables low", int'(ce | ve), 0);

    // R7 R10: no convergence, walking single-bit parity (R4)
    scen = "R4 R7 R10 no convergence";
    target[0] = 99; target[1] = 99;
    clear_rec(0); clear_rec(1);
    load(1);
    check("R2 loaded slot on check side next", int'(ce), 1);
    load(0);
    run(130);
    check("R7 done slot1 after 120", done_at[1] - load_cyc[1], 120);
    check("R7 done slot0 after 120", done_at[0] - load_cyc[0], 120);
    check("R8 decide at budget end slot1", dec_at[1] - load_cyc[1], 120);

    // R5 R6: zero parity from the start, and convergence after 3 iterations
    scen = "R5 R6 R10 early termination";
    target[1] = 0; target[0] = 3;
    clear_rec(0); clear_rec(1);
    load(1);
    load(0);
    run(130);
    check("R5 first-iteration zeros ignored, decide at 16", dec_at[1] - load_cyc[1], 16);
    check("R8 decide after 3 iterations at 32", dec_at[0] - load_cyc[0], 32);
    check("R10 done slot1 still at 120", done_at[1] - load_cyc[1], 120);
    check("R10 done slot0 still at 120", done_at[0] - load_cyc[0], 120);

    // R9: reload mid-frame after convergence
    scen = "R9 reload";
    target[1] = 2;
    clear_rec(1);
    load(1);
    run(40);
    check("R6 converged slot gated", (m_side == 1) ? int'(ce) : int'(ve), 0);
    target[1] = 99;
    clear_rec(1);
    load(1);
    tick();
    check("R9 enable restored", int'(ce), 1);
    run(125);
    check("R9 done 120 after reload", done_at[1] - load_cyc[1], 120);

    // R8: back-to-back load at the budget-end edge keeps the strobe
    scen = "R8 back-to-back";
    target[0] = 99;
    clear_rec(0);
    load(0);
    while (cyc < load_cyc[0] + 112) tick();
    target[0] = 4;
    load(0);
    check("R8 strobe survives same-edge reload", int'(m_dec[0] == 1 && dec_at[0] >= 0), 1);
    check("R8 strobe at 120", dec_at[0] - (load_cyc[0] - 120), 120);
    clear_rec(0);
    tick();
    check("R9 back-to-back enable on", int'(ce), 1);
    run(125);
    check("R8 second frame decide at 40", dec_at[0] - load_cyc[0], 40);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog [%s]: got timeout expected completion", scen);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule